// File: doc/BRIEF.md
# Video Link Pass Qualification Monitor

This block watches one received video link and decides whether the link is good enough to report as passing. It sees the receiver lock level, frame-start, frame-end and line strobes, the length of each line, a parity-error strobe and a frozen-image level that an external detector supplies. From these it measures each frame's line count and line length, compares them with the frame before, and counts consecutive valid frames. The `pass` output rises once a programmed number of good frames has been seen.

A set of independently enabled checks can pull `pass` down. These are line-count change, line-length change, parity errors in a transient or a sticky mode, and frozen video. A watchdog also drops `pass` when no frame end arrives within twice the measured frame period. Each check has its own rule for when `pass` may come back. Control bits are written through a single write-strobed register.

Top module: `vlink_pass_mon`

## Requirements
- R1: A write with `cfg_we` high loads `cfg_wdata` into the control register. Bit 0 enables the line-count check. Bit 1 enables the line-length check. Bit 2 enables the freeze check. Bit 3 selects sticky parity mode. Bit 4 turns the watchdog off. Bits 6:5 hold the threshold. Reset clears all bits, so every check is off, the watchdog is on and the threshold is 0.
- R2: With threshold N > 0, `pass` rises in the cycle after the frame end of the N-th consecutive valid frame. A frame counts only when its frame start was seen while locked. With threshold 0, `pass` is high from the cycle after `rx_lock` is seen high.
- R3: With the line-count check on, a frame whose count of `line_strobe` pulses differs from the previous frame's count drops `pass` and clears the valid-frame count. That frame is not counted. `pass` returns only after the threshold is met again.
- R4: With the line-length check on, a frame whose first-line `line_len` differs from the previous frame's first-line length drops `pass` and clears the count. That frame is not counted.
- R5: In parity mode 0 (bit 3 = 0), a `parity_err` pulse drops `pass` for exactly one cycle. The valid-frame count is kept.
- R6: In parity mode 1 (bit 3 = 1), a `parity_err` pulse drops `pass` and clears the count. The frame that holds the error is not counted, so `pass` stays low until the threshold is met again.
- R7: With the freeze check on, `frozen` high drops `pass` and clears the count. After `frozen` falls, the first complete frame only clears the hold and is not counted. The threshold is then counted afresh.
- R8: The frame period is the number of cycles between two frame starts. Once one period has been measured, `pass` drops when no frame end arrives within twice that period. The next frame after the timeout is not counted.
- R9: The watchdog has no effect while bit 4 is set, or while the threshold is 0.
- R10: Loss of `rx_lock` clears `pass` in the next cycle. It also resets the valid-frame count and forgets the reference line count, line length and period.
- R11: The first frame after lock sets the reference and cannot fail the frame-change checks. A disabled frame-change check ignores any change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 7 | Control register write data |
| rx_lock | input | 1 | Receiver lock level |
| frame_start | input | 1 | Frame-start strobe |
| frame_end | input | 1 | Frame-end strobe |
| line_strobe | input | 1 | One pulse per received line |
| line_len | input | LEN_W | Length of the line marked by `line_strobe` |
| parity_err | input | 1 | Parity-error strobe |
| frozen | input | 1 | Frozen-image level from an external detector |
| pass | output | 1 | Link pass status |

## Verification
The bench targets the recovery rules, because a design that treats every check alike would bring `pass` back too early or hold it low too long. In the sticky parity case, counting the errored frame would raise `pass` one frame early. After a freeze, counting the first clean frame would do the same. In the transient parity case, a design that cleared the count would leave `pass` low for whole frames instead of one cycle. The watchdog is probed just inside and well beyond twice the period, before one period has been measured, with the disable bit set and at threshold 0. A design that arms too early or ignores those conditions drops `pass` while frames are idle. A change in line count after a relock must not fail, which exposes a reference that survives loss of lock.

// File: rtl/vlink_pass_mon.sv
module vlink_pass_mon #(
  parameter int LINES_W = 12,
  parameter int LEN_W   = 14,
  parameter int PER_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [6:0]       cfg_wdata,
  input  logic             rx_lock,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             line_strobe,
  input  logic [LEN_W-1:0] line_len,
  input  logic             parity_err,
  input  logic             frozen,
  output logic             pass
);
  localparam int WD_W = PER_W + 1;

  logic [6:0] cfg_q;
  wire chk_lines  = cfg_q[0];
  wire chk_size   = cfg_q[1];
  wire chk_freeze = cfg_q[2];
  wire par_sticky = cfg_q[3];
  wire wdog_off   = cfg_q[4];
  wire [1:0] thr  = cfg_q[6:5];

  logic               in_frame, frm_bad, frz_hold;
  logic [LINES_W-1:0] lcnt, ref_lines;
  logic [LEN_W-1:0]   cur_size, ref_size;
  logic               ref_valid;
  logic [1:0]         vcnt;
  logic [PER_W-1:0]   per_cnt, period;
  logic               seen_start, per_valid;
  logic [WD_W-1:0]    wd_cnt;

  wire eval      = rx_lock && frame_end && in_frame;
  wire lines_bad = eval && ref_valid && chk_lines && (lcnt != ref_lines);
  wire size_bad  = eval && ref_valid && chk_size && (cur_size != ref_size);
  wire par_hard  = parity_err && par_sticky;
  wire frz_now   = chk_freeze && frozen;
  wire timeout   = per_valid && !wdog_off && (thr != 2'd0) && (wd_cnt >= {period, 1'b0});
  wire fail      = lines_bad || size_bad || par_hard || frz_now || timeout;
  wire good_end  = eval && !fail && !frm_bad && !frz_hold;

  logic [1:0] vcnt_n;
  logic       hold_n, pass_n;

  always_comb begin
    if (!rx_lock || fail)              vcnt_n = 2'd0;
    else if (good_end && (vcnt < thr)) vcnt_n = vcnt + 2'd1;
    else                               vcnt_n = vcnt;

    if (!rx_lock || !chk_freeze) hold_n = 1'b0;
    else if (frozen)             hold_n = 1'b1;
    else if (eval)               hold_n = 1'b0;
    else                         hold_n = frz_hold;

    pass_n = rx_lock && !fail && !hold_n && !parity_err && (vcnt_n >= thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      frm_bad  <= 1'b0;
      lcnt     <= '0;
      cur_size <= '0;
    end else if (!rx_lock) begin
      in_frame <= 1'b0;
      frm_bad  <= 1'b0;
      lcnt     <= '0;
    end else if (frame_start) begin
      in_frame <= 1'b1;
      frm_bad  <= par_hard || timeout || frz_now;
      lcnt     <= line_strobe ? LINES_W'(1) : '0;
      if (line_strobe) cur_size <= line_len;
    end else begin
      if (frame_end) in_frame <= 1'b0;
      frm_bad <= frm_bad || par_hard || timeout || frz_now;
      if (line_strobe && in_frame) begin
        if (lcnt == '0) cur_size <= line_len;
        if (lcnt != '1) lcnt <= lcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_valid <= 1'b0;
      ref_lines <= '0;
      ref_size  <= '0;
    end else if (!rx_lock) begin
      ref_valid <= 1'b0;
    end else if (eval) begin
      ref_valid <= 1'b1;
      ref_lines <= lcnt;
      ref_size  <= cur_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt    <= '0;
      period     <= '0;
      seen_start <= 1'b0;
      per_valid  <= 1'b0;
    end else if (!rx_lock) begin
      per_cnt    <= '0;
      seen_start <= 1'b0;
      per_valid  <= 1'b0;
    end else if (frame_start) begin
      per_cnt    <= '0;
      seen_start <= 1'b1;
      if (seen_start) begin
        period    <= (per_cnt == '1) ? per_cnt : per_cnt + 1'b1;
        per_valid <= 1'b1;
      end
    end else if (per_cnt != '1) begin
      per_cnt <= per_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      wd_cnt <= '0;
    else if (!rx_lock || frame_end)  wd_cnt <= '0;
    else if (wd_cnt != '1)           wd_cnt <= wd_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt     <= '0;
      frz_hold <= 1'b0;
      pass     <= 1'b0;
    end else begin
      vcnt     <= vcnt_n;
      frz_hold <= hold_n;
      pass     <= pass_n;
    end
  end
endmodule

// File: rtl/vlink_pass_mon_chk.sv
module vlink_pass_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] cfg_q,
  input logic       rx_lock,
  input logic       frame_end,
  input logic       parity_err,
  input logic       frozen,
  input logic       pass
);
  a_r10_lock_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_lock |=> !pass);

  a_r5_parity_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lock && parity_err |=> !pass);

  a_r7_freeze_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lock && cfg_q[2] && frozen |=> !pass);

  a_r2_zero_thresh: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lock && cfg_q[6:5] == 2'd0 && !cfg_q[2] && !parity_err && !frame_end |=> pass);

  a_r2_rise_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) && cfg_q[6:5] != 2'd0 && $past(cfg_q) == $past(cfg_q, 2)
    |-> $past(frame_end) || $past(parity_err, 2));
endmodule

bind vlink_pass_mon vlink_pass_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .rx_lock(rx_lock),
  .frame_end(frame_end), .parity_err(parity_err), .frozen(frozen), .pass(pass)
);

// File: tb/vlink_pass_mon_test.sv
`timescale 1ns/1ps
module vlink_pass_mon_test;
  localparam int LEN_W = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic rx_lock = 1'b0, frame_start = 1'b0, frame_end = 1'b0, line_strobe = 1'b0;
  logic [LEN_W-1:0] line_len = '0;
  logic parity_err = 1'b0, frozen = 1'b0;
  logic pass;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  vlink_pass_mon #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .rx_lock(rx_lock), .frame_start(frame_start), .frame_end(frame_end),
    .line_strobe(line_strobe), .line_len(line_len), .parity_err(parity_err),
    .frozen(frozen), .pass(pass)
  );

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (pass !== exp) begin
      errors++;
      $display("FAIL %s: pass=%0b expected %0b at %0t", tag, pass, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bits: 0 lines, 1 size, 2 freeze, 3 sticky parity, 4 wdog off, 6:5 threshold
  task automatic restart(input logic [6:0] cfg);
    rx_lock = 1'b0; cyc(1);
    cfg_we = 1'b1; cfg_wdata = cfg; cyc(1);
    cfg_we = 1'b0; rx_lock = 1'b1; cyc(1);
  endtask

  task automatic frame(input int nl, input int len, input bit perr);
    frame_start = 1'b1; cyc(1); frame_start = 1'b0;
    for (int i = 0; i < nl; i++) begin
      line_strobe = 1'b1; line_len = LEN_W'(len);
      if (perr && i == 1) parity_err = 1'b1;
      cyc(1);
      line_strobe = 1'b0; parity_err = 1'b0; cyc(1);
    end
    frame_end = 1'b1; cyc(1); frame_end = 1'b0;
    cyc(2);
  endtask

  task automatic t_defaults;
    chk(1'b0, "R1 reset pass low");
    rx_lock = 1'b1; cyc(1);
    chk(1'b1, "R1 default threshold 0 passes on lock");
    frame(4, 100, 0); frame(6, 50, 0);
    chk(1'b1, "R11 disabled checks ignore change");
    cyc(100);
    chk(1'b1, "R9 watchdog idle at threshold 0");
  endtask

  task automatic t_thresh;
    restart(7'b11_00000);
    chk(1'b0, "R2 threshold 3 not met at lock");
    frame(4, 100, 0); frame(4, 100, 0);
    chk(1'b0, "R2 two of three frames");
    frame(4, 100, 0);
    chk(1'b1, "R2 third frame meets threshold");
  endtask

  task automatic t_lines;
    restart(7'b10_00001);
    frame(4, 100, 0); frame(4, 100, 0);
    chk(1'b1, "R3 stable line count passes");
    frame(5, 100, 0);
    chk(1'b0, "R3 line count change drops pass");
    frame(5, 100, 0);
    chk(1'b0, "R3 one frame after change");
    frame(5, 100, 0);
    chk(1'b1, "R3 threshold met again");
  endtask

  task automatic t_size;
    restart(7'b10_00010);
    frame(4, 100, 0); frame(4, 100, 0);
    chk(1'b1, "R4 stable length passes");
    frame(4, 120, 0);
    chk(1'b0, "R4 length change drops pass");
    frame(4, 120, 0);
    chk(1'b0, "R4 one frame after change");
    frame(4, 120, 0);
    chk(1'b1, "R4 threshold met again");
  endtask

  task automatic t_par0;
    restart(7'b10_00000);
    frame(4, 100, 0); frame(4, 100, 0);
    chk(1'b1, "R5 passing before error");
    parity_err = 1'b1; cyc(1); parity_err = 1'b0;
    chk(1'b0, "R5 transient drop");
    cyc(1);
    chk(1'b1, "R5 recovers next cycle");
  endtask

  task automatic t_par1;
    restart(7'b10_01000);
    frame(4, 100, 0); frame(4, 100, 0);
    chk(1'b1, "R6 passing before error");
    frame(4, 100, 1);
    chk(1'b0, "R6 errored frame not counted");
    frame(4, 100, 0);
    chk(1'b0, "R6 one clean frame");
    frame(4, 100, 0);
    chk(1'b1, "R6 threshold met again");
  endtask

  task automatic t_freeze;
    restart(7'b01_00100);
    frame(4, 100, 0);
    chk(1'b1, "R7 passing before freeze");
    frozen = 1'b1; cyc(1);
    chk(1'b0, "R7 freeze drops pass");
    frame(4, 100, 0);
    chk(1'b0, "R7 frozen frame");
    frozen = 1'b0;
    frame(4, 100, 0);
    chk(1'b0, "R7 first new image only clears hold");
    frame(4, 100, 0);
    chk(1'b1, "R7 threshold met after new image");
  endtask

  task automatic t_wdog;
    restart(7'b01_00000);
    frame(4, 100, 0);
    chk(1'b1, "R8 single frame passes");
    cyc(100);
    chk(1'b1, "R8 not armed before a period is measured");
    restart(7'b01_00000);
    frame(4, 100, 0); frame(4, 100, 0);
    cyc(18);
    chk(1'b1, "R8 within two periods");
    cyc(10);
    chk(1'b0, "R8 timeout after two periods");
    frame(4, 100, 0);
    chk(1'b0, "R8 frame after timeout not counted");
    frame(4, 100, 0);
    chk(1'b1, "R8 recovers");
  endtask

  task automatic t_wdog_off;
    restart(7'b01_10000);
    frame(4, 100, 0); frame(4, 100, 0);
    cyc(100);
    chk(1'b1, "R9 watchdog disabled");
  endtask

  task automatic t_lock;
    restart(7'b01_00001);
    frame(4, 100, 0);
    chk(1'b1, "R10 passing before lock loss");
    rx_lock = 1'b0; cyc(1);
    chk(1'b0, "R10 lock loss clears pass");
    rx_lock = 1'b1; cyc(1);
    frame(6, 100, 0);
    chk(1'b1, "R10 R11 reference forgotten, first frame sets it");
    restart(7'b10_00000);
    frame(4, 100, 0); frame(4, 100, 0);
    rx_lock = 1'b0; cyc(1); rx_lock = 1'b1; cyc(1);
    frame(4, 100, 0);
    chk(1'b0, "R10 count cleared by lock loss");
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_defaults;
    t_thresh;
    t_lines;
    t_size;
    t_par0;
    t_par1;
    t_freeze;
    t_wdog;
    t_wdog_off;
    t_lock;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule